// File: doc/BRIEF.md
# Periodic Pulse Burst Gate

This block turns a steady base tick into short bursts. Once per frame it lets a chosen number of base ticks through, from one to nine, and blocks every other tick until the next frame starts. The base tick comes from a clock-cycle divider with two rates, fast and slow. A twelve-stage binary prescaler counts base ticks and sets the frame length. A two-bit tap code moves the frame boundary between stage 9, stage 10 and stage 11. A downstream up/down counter takes the burst output as its count enable and the direction level as its count direction.

Four active-low request inputs drive the block. Two choose the tick rate and two choose the count direction. The request inputs must already be synchronous to `clk`. Filtering of the raw inputs and any analogue stage are outside this block.

Top module: `pulse_burst_gate`

## Requirements
- R1: A synchronous active-high `rst` holds `burst_tick` low and `dir_up` high, and clears the prescaler and the burst counter. Reset therefore acts as a frame start: once a rate request is active, the first burst begins without waiting for a boundary.
- R2: When `rate_fast_req_n` is low, a base tick occurs every FAST_DIV clock cycles. When only `rate_slow_req_n` is low, a base tick occurs every SLOW_DIV cycles. If both are low, fast wins.
- R3: When neither rate request is low, the divider holds and `burst_tick` stays low from the second cycle onward.
- R4: A frame lasts 2^S base ticks. S is 9 for `frame_tap_sel`=0, 10 for codes 1 and 3, and 11 for code 2.
- R5: The boundary tick is the base tick on which the low S bits of the prescaler are all ones. That tick is blocked and it clears the burst counter. The next L base ticks pass to the output, and the ticks after them are blocked until the next boundary.
- R6: L is `burst_len` read as an unsigned number, with 0 treated as 1 and any value above 9 treated as 9.
- R7: Each passed tick appears on `burst_tick` as a registered pulse exactly one clock wide. Two pulses never fall in adjacent cycles.
- R8: `dir_up` is a register. A low `dir_down_req_n` sets it to 0 on the next edge. Otherwise a low `dir_up_req_n` sets it to 1. With neither request low it holds its value. Down has priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_fast_req_n | input | 1 | Fast tick rate request, active low |
| rate_slow_req_n | input | 1 | Slow tick rate request, active low |
| dir_up_req_n | input | 1 | Count-up request, active low |
| dir_down_req_n | input | 1 | Count-down request, active low, wins over up |
| frame_tap_sel | input | 2 | Prescaler stage selecting the frame length |
| burst_len | input | 4 | Ticks passed per frame, clamped to 1..9 |
| burst_tick | output | 1 | Registered one-cycle burst pulse |
| dir_up | output | 1 | Registered direction level, 1 means up |

## Verification
The bench runs bursts with lengths 3, 9, 5 and the clamped codes 0 and 12. If a design got the clamp wrong, it would emit an empty burst or one longer than nine. The spacing between burst starts is measured at every tap code. A design that passed the boundary tick, or decoded the wrong prescaler stage, would show a burst one tick too long or a frame of the wrong length. The bench also exercises both rate requests together, no request at all, reset in the middle of a run, and the case where both direction requests are active. These catch a design with the wrong rate or direction priority, a design that leaks pulses while idle, and a design that waits a full frame after reset.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int PRE_STAGES = 12;
    localparam int LEN_W      = 4;
    localparam int MAX_BURST  = 9;

    typedef enum logic [1:0] {
        TAP_SHORT   = 2'd0,
        TAP_NOMINAL = 2'd1,
        TAP_LONG    = 2'd2,
        TAP_ALT     = 2'd3
    } tap_e;

    // Burst length actually used: zero becomes one, anything past the limit saturates
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw == '0)
            return LEN_W'(1);
        else if (raw > LEN_W'(MAX_BURST))
            return LEN_W'(MAX_BURST);
        else
            return raw;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int FAST_DIV = 50000,
    parameter int SLOW_DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int DIV_MAX = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int CW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CW-1:0] lim;
    logic          active;

    always_comb begin
        st_d   = st_q;
        active = fast_i | slow_i;
        lim    = fast_i ? FAST_LIM : SLOW_LIM;
        st_d.tick = active && (st_q.cnt == lim);
        if (!active)
            st_d.cnt = '0;
        else if (st_q.cnt >= lim)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R2: with divisors of two or more, a tick never repeats on the next cycle
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.tick |=> !st_q.tick);

endmodule

// File: rtl/frame_prescaler.sv
module frame_prescaler
    import burst_pkg::*;
#(
    parameter int STAGES        = PRE_STAGES,
    parameter int NOMINAL_STAGE = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  tap_e tap_i,
    output logic frame_o
);
    localparam logic [STAGES-1:0] MASK_SHORT = STAGES'((64'd1 << (NOMINAL_STAGE - 1)) - 64'd1);
    localparam logic [STAGES-1:0] MASK_NOM   = STAGES'((64'd1 << NOMINAL_STAGE) - 64'd1);
    localparam logic [STAGES-1:0] MASK_LONG  = STAGES'((64'd1 << (NOMINAL_STAGE + 1)) - 64'd1);

    typedef struct packed {
        logic [STAGES-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [STAGES-1:0] mask;

    always_comb begin
        case (tap_i)
            TAP_SHORT: mask = MASK_SHORT;
            TAP_LONG:  mask = MASK_LONG;
            default:   mask = MASK_NOM;
        endcase
        st_d = st_q;
        if (tick_i)
            st_d.pre = st_q.pre + 1'b1;
        frame_o = tick_i && ((st_q.pre & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R4: the prescaler advances by exactly one on each tick
    assert_pre_step_R4: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> st_q.pre == $past(st_q.pre) + 1'b1);

    // R4: between ticks the prescaler does not move
    assert_pre_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(st_q.pre));

endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             frame_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             burst_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             out;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [LEN_W-1:0] len_eff;

    always_comb begin
        len_eff   = clamp_len(len_i);
        st_d      = st_q;
        st_d.out  = 1'b0;
        if (frame_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt < len_eff)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign burst_o = st_q.out;

    // R5: a frame boundary always leaves the counter empty
    assert_frame_clears_R5: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> st_q.cnt == '0);

    // R7: every output pulse is one clock wide
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.out |=> !st_q.out);

    // R6: the count never runs past the longest burst
    assert_len_bound_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.out |-> (st_q.cnt >= LEN_W'(1)) && (st_q.cnt <= LEN_W'(MAX_BURST)));

endmodule

// File: rtl/pulse_burst_gate.sv
module pulse_burst_gate
    import burst_pkg::*;
#(
    parameter int FAST_DIV      = 50000,
    parameter int SLOW_DIV      = 100000,
    parameter int NOMINAL_STAGE = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_fast_req_n,
    input  logic             rate_slow_req_n,
    input  logic             dir_up_req_n,
    input  logic             dir_down_req_n,
    input  logic [1:0]       frame_tap_sel,
    input  logic [LEN_W-1:0] burst_len,
    output logic             burst_tick,
    output logic             dir_up
);
    typedef struct packed {
        logic dir;
    } dir_st_t;

    dir_st_t st_d, st_q;
    logic    base_tick;
    logic    frame_hit;

    tick_divider #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .fast_i (!rate_fast_req_n),
        .slow_i (!rate_slow_req_n),
        .tick_o (base_tick)
    );

    frame_prescaler #(
        .STAGES        (PRE_STAGES),
        .NOMINAL_STAGE (NOMINAL_STAGE)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (base_tick),
        .tap_i   (tap_e'(frame_tap_sel)),
        .frame_o (frame_hit)
    );

    burst_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (base_tick),
        .frame_i (frame_hit),
        .len_i   (burst_len),
        .burst_o (burst_tick)
    );

    always_comb begin
        st_d = st_q;
        if (!dir_down_req_n)
            st_d.dir = 1'b0;
        else if (!dir_up_req_n)
            st_d.dir = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{dir: 1'b1};
        else
            st_q <= st_d;
    end

    assign dir_up = st_q.dir;

    // R8: a down request wins on the following edge
    assert_dir_down_R8: assert property (@(posedge clk) disable iff (rst)
        !dir_down_req_n |=> !dir_up);

    // R8: an up request alone drives the level high
    assert_dir_up_R8: assert property (@(posedge clk) disable iff (rst)
        (!dir_up_req_n && dir_down_req_n) |=> dir_up);

    // R3: with no rate request, nothing reaches the output two cycles later
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (rate_fast_req_n && rate_slow_req_n) |=> ##1 !burst_tick);

endmodule

// File: tb/test_pulse_burst_gate.sv
module test_pulse_burst_gate;
    localparam int FD = 2;
    localparam int SD = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_n = 1'b1, slow_n = 1'b1, up_n = 1'b1, down_n = 1'b1;
    logic [1:0] tap = 2'd1;
    logic [3:0] len = 4'd3;
    logic       burst_tick, dir_up;

    int total = 0, bad = 0;
    bit finished = 0;

    pulse_burst_gate #(.FAST_DIV(FD), .SLOW_DIV(SD), .NOMINAL_STAGE(10)) i_pulse_burst_gate (
        .clk(clk), .rst(rst),
        .rate_fast_req_n(fast_n), .rate_slow_req_n(slow_n),
        .dir_up_req_n(up_n), .dir_down_req_n(down_n),
        .frame_tap_sel(tap), .burst_len(len),
        .burst_tick(burst_tick), .dir_up(dir_up)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    int m_div = 0, m_pre = 0, m_cnt = 0;
    bit m_tick = 0, m_out = 0, m_dir = 1;

    function automatic int eff_len(input int raw);
        if (raw == 0) return 1;
        if (raw > 9) return 9;
        return raw;
    endfunction

    function automatic int stage_of(input int code);
        if (code == 0) return 9;
        if (code == 2) return 11;
        return 10;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_pre = 0; m_cnt = 0; m_tick = 0; m_out = 0; m_dir = 1;
        end else begin
            int lim, msk;
            bit act, nt, no;
            act = !fast_n || !slow_n;
            lim = (!fast_n) ? FD - 1 : SD - 1;
            no = 0;
            if (m_tick) begin
                msk = (1 << stage_of(tap)) - 1;
                if ((m_pre & msk) == msk) m_cnt = 0;
                else if (m_cnt < eff_len(len)) begin m_cnt++; no = 1; end
                m_pre = (m_pre + 1) % 4096;
            end
            nt = act && (m_div == lim);
            if (!act || m_div >= lim) m_div = 0; else m_div++;
            m_tick = nt;
            m_out = no;
            if (!down_n) m_dir = 0; else if (!up_n) m_dir = 1;
        end
    end

    // Per-cycle comparison and burst shape measurement on falling edges
    int cyc = 0, last_pulse = -1000, start_cyc = 0, cur_cnt = 0;
    bit prev_bt = 0, have_start = 0, meas_en = 0;
    int exp_len = 0, exp_period = 0, exp_gap = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check(burst_tick == m_out, "R5", burst_tick, m_out);
            check(dir_up == m_dir, "R8", dir_up, m_dir);
            if (burst_tick) check(!prev_bt, "R7", prev_bt, 0);
        end
        if (burst_tick) begin
            if (cyc - last_pulse > 40) begin
                if (meas_en && have_start) begin
                    check(cur_cnt == exp_len, "R6", cur_cnt, exp_len);
                    check(cyc - start_cyc == exp_period, "R4", cyc - start_cyc, exp_period);
                end
                have_start = 1; start_cyc = cyc; cur_cnt = 1;
            end else begin
                cur_cnt++;
                if (meas_en) check(cyc - last_pulse == exp_gap, "R2", cyc - last_pulse, exp_gap);
            end
            last_pulse = cyc;
        end
        prev_bt = burst_tick;
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply a rate/tap/length setting, let one frame settle, then measure frames
    task automatic run_setting(input bit f, input bit s, input int tcode, input int l, input int frames);
        int div, period;
        div = f ? FD : SD;
        period = (1 << stage_of(tcode)) * div;
        @(negedge clk);
        fast_n = !f; slow_n = !s; tap = 2'(tcode); len = 4'(l);
        @(posedge clk); meas_en = 0;
        wait_cycles(period + 20);
        @(posedge clk);
        have_start = 0; exp_len = eff_len(l); exp_period = period; exp_gap = div; meas_en = 1;
        wait_cycles(period * frames + 20);
        @(posedge clk); meas_en = 0;
    endtask

    initial begin
        int seen;
        // R1: outputs during reset
        wait_cycles(4);
        check(burst_tick == 0, "R1", burst_tick, 0);
        check(dir_up == 1, "R1", dir_up, 1);
        fast_n = 0;
        rst = 0;
        // R1: the first burst begins right away
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (burst_tick) seen++; end
        check(seen == 3, "R1", seen, 3);

        // R8: direction priority and hold
        down_n = 0; wait_cycles(2);
        check(dir_up == 0, "R8", dir_up, 0);
        up_n = 0; wait_cycles(2);
        check(dir_up == 0, "R8", dir_up, 0);
        down_n = 1; wait_cycles(2);
        check(dir_up == 1, "R8", dir_up, 1);
        up_n = 1; wait_cycles(3);
        check(dir_up == 1, "R8", dir_up, 1);

        run_setting(1, 0, 1, 3, 2);    // R4, R5 nominal frame
        run_setting(0, 1, 0, 9, 2);    // R2 slow rate, short frame, longest burst
        run_setting(1, 1, 2, 0, 2);    // R2 fast wins, long frame, R6 zero clamps to one
        run_setting(1, 0, 3, 12, 2);   // R6 oversize clamps to nine, alternate nominal code
        run_setting(0, 1, 2, 5, 1);

        // R3: no rate request leaves the output quiet
        @(negedge clk); fast_n = 1; slow_n = 1;
        wait_cycles(3);
        seen = 0;
        for (int i = 0; i < 5000; i++) begin @(negedge clk); if (burst_tick) seen++; end
        check(seen == 0, "R3", seen, 0);

        // R1: reset in mid run, then an immediate burst
        fast_n = 0; len = 4'd4; tap = 2'd1;
        wait_cycles(700);
        down_n = 0; wait_cycles(2); down_n = 1;
        rst = 1; wait_cycles(3);
        check(burst_tick == 0, "R1", burst_tick, 0);
        check(dir_up == 1, "R1", dir_up, 1);
        rst = 0;
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (burst_tick) seen++; end
        check(seen == 4, "R1", seen, 4);
        wait_cycles(10);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule